// File: doc/BRIEF.md
# Long Branch Bundle Executor

This block executes a long relative branch or a long call carried in a 128-bit instruction bundle. The bundle arrives as two 64-bit words. The block also takes the address of the current bundle, the slot index, a 64-bit predicate vector, the current frame marker, the epilogue count and the privilege level. The caller pulses `start_i` with all inputs valid. One cycle later `done_o` pulses, and the registered outputs show the result.

The result gives the next bundle address and the new slot index. It also gives an optional branch-register write (index and data), an optional new previous-frame-state value and the new frame marker. If the bundle is not a valid long branch or long call, `unhandled_o` is raised instead. Fetching the instruction, the register file itself and fault delivery are outside this block.

Top module: `long_branch_exec`

## Requirements
- R1: An instruction is accepted only when `slot_i` equals 1 and `word0_i[4:1]` equals 4'b0010. `word0_i[0]` is ignored. If it is not accepted, `unhandled_o` is 1, `next_addr_o` equals `addr_i`, `next_slot_o` equals `slot_i`, `br_we_o` and `pfs_we_o` are 0, and `frame_o` equals `frame_i`.
- R2: The opcode is `word1_i[63:60]` and the branch type is `word1_i[31:29]`. Opcode 4'hC is a long branch, legal only with branch type 0. Opcode 4'hD is a long call with any branch type. Any other combination gives the R1 "not handled" result.
- R3: The predicate index is `word1_i[28:23]`. When `pred_i` at that index is 0, a legal instruction produces `next_addr_o` = `addr_i` + 16 and `next_slot_o` = 0. It produces no branch-register write and no frame-state write, and `frame_o` equals `frame_i`.
- R4: The displacement is assembled as follows. Bit 63 takes `word1_i[59]`. Bits 62:40 take `word1_i[22:0]`. Bits 39:24 take `word0_i[63:48]`. Bits 23:4 take `word1_i[55:36]`. Bits 3:0 are zero. When the predicate is 1, `next_addr_o` = `addr_i` + displacement, wrapping modulo 2^64, and `next_slot_o` = 0.
- R5: A long call whose predicate is 1 sets `br_we_o`. It writes `addr_i` + 16 on `br_data_o`, and `br_idx_o` equals the branch type.
- R6: A long call whose predicate is 1 sets `pfs_we_o`. In `pfs_o`, bits 37:0 hold `frame_i[37:0]`, bits 57:52 hold `epi_cnt_i`, bits 63:62 hold `priv_i`, and all other bits are 0.
- R7: A long call whose predicate is 1 sets `frame_o` as follows. Clear bits 37:7 of `frame_i` and keep the rest. Then subtract `frame_i[13:7]` from the result, modulo 2^64.
- R8: `done_o` is 1 exactly in the cycle after a cycle with `start_i` high. The outputs change only on such a cycle and hold otherwise. After reset, every output is 0.
- R9: A long branch whose predicate is 1 makes no branch-register write and no frame-state write, and `frame_o` equals `frame_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Execute the presented bundle |
| word0_i | input | 64 | Bundle low word |
| word1_i | input | 64 | Bundle high word |
| addr_i | input | 64 | Current bundle address |
| slot_i | input | 2 | Current slot index |
| pred_i | input | 64 | Predicate vector |
| frame_i | input | 64 | Current frame marker |
| epi_cnt_i | input | 6 | Epilogue count |
| priv_i | input | 2 | Current privilege level |
| done_o | output | 1 | Result valid pulse |
| next_addr_o | output | 64 | Next bundle address |
| next_slot_o | output | 2 | Next slot index |
| br_we_o | output | 1 | Branch-register write enable |
| br_idx_o | output | 3 | Branch-register index |
| br_data_o | output | 64 | Branch-register write data (return address) |
| pfs_we_o | output | 1 | Previous-frame-state write enable |
| pfs_o | output | 64 | New previous-frame-state value |
| frame_o | output | 64 | New frame marker |
| unhandled_o | output | 1 | Bundle is not a legal long branch or call |

## Verification
The assertions sample the bundle, address, slot and predicate inputs only in the cycle where `start_i` is high. They assume those inputs are stable across that clock edge, and they assume nothing about the inputs in any other cycle. The bench changes every input only on the falling clock edge and holds `start_i` high for exactly one cycle at a time. It inserts idle cycles between starts, so each property's single-cycle look-back always lands on the start cycle it refers to. The filler bits of the bundle are driven to nonzero patterns, so that decoding from the wrong field would show up.

// File: rtl/lbx_pkg.sv
package lbx_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned SLOT_W   = 2;
  localparam int unsigned BR_IDX_W = 3;
  localparam int unsigned QP_W     = 6;
  localparam int unsigned EPI_W    = 6;
  localparam int unsigned PRIV_W   = 2;
  localparam int unsigned OPC_W    = 4;
  localparam int unsigned TMPL_W   = 4;

  localparam logic [TMPL_W-1:0] TMPL_LONG   = 4'b0010;
  localparam logic [SLOT_W-1:0] SLOT_LONG   = 2'd1;
  localparam logic [OPC_W-1:0]  OPC_LBR     = 4'hC;
  localparam logic [OPC_W-1:0]  OPC_LCALL   = 4'hD;
  localparam logic [XLEN-1:0]   BUNDLE_STEP = 64'd16;

  typedef enum logic [1:0] {
    OPK_NONE   = 2'd0,
    OPK_BRANCH = 2'd1,
    OPK_CALL   = 2'd2
  } op_kind_e;

  typedef struct packed {
    logic [XLEN-1:0]     next_addr;
    logic [SLOT_W-1:0]   next_slot;
    logic                br_we;
    logic [BR_IDX_W-1:0] br_idx;
    logic [XLEN-1:0]     br_data;
    logic                pfs_we;
    logic [XLEN-1:0]     pfs;
    logic [XLEN-1:0]     frame;
    logic                unhandled;
  } lbx_result_t;
endpackage

// File: rtl/lbx_decode.sv
module lbx_decode
  import lbx_pkg::*;
(
  input  logic [XLEN-1:0]     word0_i,
  input  logic [XLEN-1:0]     word1_i,
  input  logic [SLOT_W-1:0]   slot_i,
  output logic                accept_o,
  output op_kind_e            kind_o,
  output logic [BR_IDX_W-1:0] btype_o,
  output logic [QP_W-1:0]     qp_o,
  output logic [XLEN-1:0]     disp_o
);
  localparam int unsigned OPC_LSB   = XLEN - OPC_W;
  localparam int unsigned BTYPE_LSB = 29;
  localparam int unsigned QP_LSB    = 23;

  logic [OPC_W-1:0] opcode;
  logic             unused_bits;

  assign opcode   = word1_i[OPC_LSB +: OPC_W];
  assign btype_o  = word1_i[BTYPE_LSB +: BR_IDX_W];
  assign qp_o     = word1_i[QP_LSB +: QP_W];
  assign accept_o = (slot_i == SLOT_LONG) && (word0_i[TMPL_W:1] == TMPL_LONG);

  // displacement is scattered over both words; low nibble is bundle aligned
  assign disp_o = {word1_i[59], word1_i[22:0], word0_i[63:48], word1_i[55:36], 4'h0};

  always_comb begin
    unique case (opcode)
      OPC_LBR:   kind_o = (btype_o == '0) ? OPK_BRANCH : OPK_NONE;
      OPC_LCALL: kind_o = OPK_CALL;
      default:   kind_o = OPK_NONE;
    endcase
  end

  assign unused_bits = ^{word0_i[47:5], word0_i[0], word1_i[58:56], word1_i[35:32]};
endmodule

// File: rtl/lbx_target.sv
module lbx_target
  import lbx_pkg::*;
#(
  parameter logic [XLEN-1:0] STEP = BUNDLE_STEP
) (
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] disp_i,
  input  logic            taken_i,
  output logic [XLEN-1:0] next_addr_o,
  output logic [XLEN-1:0] link_o
);
  logic [XLEN-1:0] rel_addr;

  assign link_o      = addr_i + STEP;
  assign rel_addr    = addr_i + disp_i;
  assign next_addr_o = taken_i ? rel_addr : link_o;
endmodule

// File: rtl/lbx_frame.sv
module lbx_frame
  import lbx_pkg::*;
#(
  parameter int unsigned KEEP_W   = 38,
  parameter int unsigned SOL_LSB  = 7,
  parameter int unsigned SOL_W    = 7,
  parameter int unsigned EPI_LSB  = 52,
  parameter int unsigned PRIV_LSB = 62
) (
  input  logic [XLEN-1:0]   frame_i,
  input  logic [EPI_W-1:0]  epi_cnt_i,
  input  logic [PRIV_W-1:0] priv_i,
  output logic [XLEN-1:0]   pfs_o,
  output logic [XLEN-1:0]   frame_o
);
  // bits SOL_LSB .. KEEP_W-1 are cleared on a call
  localparam logic [XLEN-1:0] CLR_MASK =
    ((64'd1 << KEEP_W) - 64'd1) & ~((64'd1 << SOL_LSB) - 64'd1);

  logic [XLEN-1:0] kept;
  logic [XLEN-1:0] sol_ext;

  always_comb begin
    pfs_o                       = '0;
    pfs_o[KEEP_W-1:0]           = frame_i[KEEP_W-1:0];
    pfs_o[EPI_LSB +: EPI_W]     = epi_cnt_i;
    pfs_o[PRIV_LSB +: PRIV_W]   = priv_i;
  end

  assign kept    = frame_i & ~CLR_MASK;
  assign sol_ext = XLEN'(frame_i[SOL_LSB +: SOL_W]);
  assign frame_o = kept - sol_ext;
endmodule

// File: rtl/long_branch_exec.sv
module long_branch_exec
  import lbx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [XLEN-1:0]     word0_i,
  input  logic [XLEN-1:0]     word1_i,
  input  logic [XLEN-1:0]     addr_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [XLEN-1:0]     pred_i,
  input  logic [XLEN-1:0]     frame_i,
  input  logic [EPI_W-1:0]    epi_cnt_i,
  input  logic [PRIV_W-1:0]   priv_i,
  output logic                done_o,
  output logic [XLEN-1:0]     next_addr_o,
  output logic [SLOT_W-1:0]   next_slot_o,
  output logic                br_we_o,
  output logic [BR_IDX_W-1:0] br_idx_o,
  output logic [XLEN-1:0]     br_data_o,
  output logic                pfs_we_o,
  output logic [XLEN-1:0]     pfs_o,
  output logic [XLEN-1:0]     frame_o,
  output logic                unhandled_o
);
  logic                accept;
  op_kind_e            kind;
  logic [BR_IDX_W-1:0] btype;
  logic [QP_W-1:0]     qp;
  logic [XLEN-1:0]     disp;
  logic                pred_bit;
  logic [XLEN-1:0]     tgt_addr;
  logic [XLEN-1:0]     link_addr;
  logic [XLEN-1:0]     pfs_calc;
  logic [XLEN-1:0]     frame_calc;
  lbx_result_t         res_d, res_q;
  logic                done_q;

  lbx_decode u_decode (
    .word0_i (word0_i),
    .word1_i (word1_i),
    .slot_i  (slot_i),
    .accept_o(accept),
    .kind_o  (kind),
    .btype_o (btype),
    .qp_o    (qp),
    .disp_o  (disp)
  );

  assign pred_bit = pred_i[qp];

  lbx_target u_target (
    .addr_i     (addr_i),
    .disp_i     (disp),
    .taken_i    (pred_bit),
    .next_addr_o(tgt_addr),
    .link_o     (link_addr)
  );

  lbx_frame u_frame (
    .frame_i  (frame_i),
    .epi_cnt_i(epi_cnt_i),
    .priv_i   (priv_i),
    .pfs_o    (pfs_calc),
    .frame_o  (frame_calc)
  );

  always_comb begin
    res_d           = '0;
    res_d.next_addr = addr_i;
    res_d.next_slot = slot_i;
    res_d.frame     = frame_i;
    res_d.unhandled = 1'b1;
    if (accept && kind != OPK_NONE) begin
      res_d.unhandled = 1'b0;
      res_d.next_slot = '0;
      res_d.next_addr = tgt_addr;
      if (pred_bit && kind == OPK_CALL) begin
        res_d.br_we   = 1'b1;
        res_d.br_idx  = btype;
        res_d.br_data = link_addr;
        res_d.pfs_we  = 1'b1;
        res_d.pfs     = pfs_calc;
        res_d.frame   = frame_calc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= start_i;
      if (start_i) res_q <= res_d;
    end
  end

  assign done_o      = done_q;
  assign next_addr_o = res_q.next_addr;
  assign next_slot_o = res_q.next_slot;
  assign br_we_o     = res_q.br_we;
  assign br_idx_o    = res_q.br_idx;
  assign br_data_o   = res_q.br_data;
  assign pfs_we_o    = res_q.pfs_we;
  assign pfs_o       = res_q.pfs;
  assign frame_o     = res_q.frame;
  assign unhandled_o = res_q.unhandled;

  // ---------------- assertions ----------------
  logic in_ok;
  logic op_ok;
  assign in_ok = (slot_i == SLOT_LONG) && (word0_i[4:1] == TMPL_LONG);
  assign op_ok = (word1_i[63:60] == OPC_LCALL) ||
                 (word1_i[63:60] == OPC_LBR && word1_i[31:29] == 3'd0);

  assert_done_after_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o && $stable(next_addr_o) && $stable(frame_o) && $stable(br_we_o));

  assert_reject_no_effect_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !in_ok |=> unhandled_o && !br_we_o && !pfs_we_o &&
      next_addr_o == $past(addr_i) && next_slot_o == $past(slot_i) && frame_o == $past(frame_i));

  assert_bad_opcode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !op_ok |=> unhandled_o);

  assert_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && in_ok && op_ok && !pred_i[word1_i[28:23]] |=>
      !unhandled_o && !br_we_o && !pfs_we_o && next_slot_o == '0 &&
      next_addr_o == $past(addr_i) + 64'd16);

  assert_call_link_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && in_ok && word1_i[63:60] == OPC_LCALL && pred_i[word1_i[28:23]] |=>
      br_we_o && pfs_we_o && br_idx_o == $past(word1_i[31:29]) &&
      br_data_o == $past(addr_i) + 64'd16);

  assert_branch_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && in_ok && word1_i[63:60] == OPC_LBR && word1_i[31:29] == 3'd0 |=>
      !br_we_o && !pfs_we_o && frame_o == $past(frame_i));
endmodule

// File: tb/long_branch_exec_tb_top.sv
`timescale 1ns/1ps
module long_branch_exec_tb_top;
  import lbx_pkg::*;

  typedef struct packed {
    logic [3:0]  op;
    logic [2:0]  btype;
    logic [5:0]  qp;
    logic        f_hi;
    logic [19:0] f_lo20;
    logic [22:0] f_mid23;
    logic [15:0] f_w0;
    logic [3:0]  tmpl;
    logic        t0;
    logic [1:0]  slot;
    logic [63:0] addr;
    logic [63:0] pred;
    logic [63:0] frame;
    logic [5:0]  epi;
    logic [1:0]  priv;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R4 taken branch, positive displacement
    '{4'hC,3'd0,6'd5, 1'b0,20'h00123,23'h0,     16'h0,   4'b0010,1'b0,2'd1,64'h1000_0000,64'h20,64'h123,6'd3,2'd1},
    // R4 taken branch, negative displacement
    '{4'hC,3'd0,6'd0, 1'b1,20'hFFFFE,23'h7FFFFF,16'hFFFF,4'b0010,1'b0,2'd1,64'h4000,64'h1,64'h0,6'd0,2'd0},
    // R3 branch not taken, top predicate index
    '{4'hC,3'd0,6'd63,1'b0,20'h00010,23'h0,     16'h0,   4'b0010,1'b0,2'd1,64'h8000,64'h7FFF_FFFF_FFFF_FFFF,64'h77,6'd1,2'd2},
    // R5 R6 R7 taken call
    '{4'hD,3'd3,6'd10,1'b0,20'h00040,23'h000001,16'h8001,4'b0010,1'b0,2'd1,64'h0000_1234_0000_0000,64'h400,64'hABCD_EF12_3456_7895,6'h2A,2'd3},
    // R7 borrow into upper bits, R1 template bit 0 ignored
    '{4'hD,3'd7,6'd1, 1'b0,20'h00002,23'h0,     16'h0,   4'b0010,1'b1,2'd1,64'h100,64'h2,64'h503,6'h3F,2'd0},
    // R3 call not taken
    '{4'hD,3'd2,6'd4, 1'b0,20'h00100,23'h0,     16'h0,   4'b0010,1'b0,2'd1,64'h2000,64'hFFFF_FFFF_FFFF_FFEF,64'h1234,6'd5,2'd1},
    // R2 unknown opcode
    '{4'hE,3'd0,6'd0, 1'b0,20'h00100,23'h0,     16'h0,   4'b0010,1'b0,2'd1,64'h3000,64'hFFFF_FFFF_FFFF_FFFF,64'h55,6'd5,2'd1},
    // R2 long branch with nonzero type
    '{4'hC,3'd1,6'd0, 1'b0,20'h00100,23'h0,     16'h0,   4'b0010,1'b0,2'd1,64'h3100,64'hFFFF_FFFF_FFFF_FFFF,64'h66,6'd5,2'd1},
    // R1 wrong slot
    '{4'hD,3'd1,6'd0, 1'b0,20'h00100,23'h0,     16'h0,   4'b0010,1'b0,2'd2,64'h3200,64'hFFFF_FFFF_FFFF_FFFF,64'h88,6'd5,2'd1},
    // R1 wrong template
    '{4'hD,3'd1,6'd0, 1'b0,20'h00100,23'h0,     16'h0,   4'b0011,1'b0,2'd1,64'h3300,64'hFFFF_FFFF_FFFF_FFFF,64'h99,6'd5,2'd1},
    // R4 address wrap
    '{4'hC,3'd0,6'd2, 1'b0,20'h00004,23'h0,     16'h0,   4'b0010,1'b0,2'd1,64'hFFFF_FFFF_FFFF_FFF0,64'h4,64'h0,6'd0,2'd0},
    // R5 call type 0, full frame marker
    '{4'hD,3'd0,6'd0, 1'b1,20'h0,    23'h0,     16'h0,   4'b0010,1'b0,2'd1,64'h10,64'hFFFF_FFFF_FFFF_FFFF,64'hFFFF_FFFF_FFFF_FFFF,6'd0,2'd0},
    // R1 slot 0
    '{4'hD,3'd5,6'd0, 1'b0,20'h00001,23'h0,     16'h0,   4'b0010,1'b0,2'd0,64'h3400,64'h1,64'hAA,6'd1,2'd1}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [63:0]       word0_i = '0, word1_i = '0, addr_i = '0, pred_i = '0, frame_i = '0;
  logic [1:0]        slot_i = '0;
  logic [5:0]        epi_cnt_i = '0;
  logic [1:0]        priv_i = '0;
  logic              done_o, br_we_o, pfs_we_o, unhandled_o;
  logic [63:0]       next_addr_o, br_data_o, pfs_o, frame_o;
  logic [1:0]        next_slot_o;
  logic [2:0]        br_idx_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  long_branch_exec dut_i (
    .clk_i, .rst_ni, .start_i, .word0_i, .word1_i, .addr_i, .slot_i, .pred_i,
    .frame_i, .epi_cnt_i, .priv_i, .done_o, .next_addr_o, .next_slot_o,
    .br_we_o, .br_idx_o, .br_data_o, .pfs_we_o, .pfs_o, .frame_o, .unhandled_o
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic lbx_result_t model(input vec_t v);
    lbx_result_t e;
    logic [63:0] disp;
    logic        legal;
    disp = {v.f_hi, v.f_mid23, v.f_w0, v.f_lo20, 4'h0};
    legal = (v.slot == 2'd1) && (v.tmpl == 4'b0010) &&
            ((v.op == 4'hC && v.btype == 3'd0) || v.op == 4'hD);
    e = '0;
    e.next_addr = v.addr;
    e.next_slot = v.slot;
    e.frame     = v.frame;
    e.unhandled = 1'b1;
    if (legal) begin
      e.unhandled = 1'b0;
      e.next_slot = 2'd0;
      if (v.pred[v.qp]) begin
        e.next_addr = v.addr + disp;
        if (v.op == 4'hD) begin
          e.br_we   = 1'b1;
          e.br_idx  = v.btype;
          e.br_data = v.addr + 64'd16;
          e.pfs_we  = 1'b1;
          e.pfs     = {v.priv, 4'h0, v.epi, 14'h0, v.frame[37:0]};
          e.frame   = {v.frame[63:38], 31'h0, v.frame[6:0]} - {57'h0, v.frame[13:7]};
        end
      end else begin
        e.next_addr = v.addr + 64'd16;
      end
    end
    return e;
  endfunction

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    word0_i   = {v.f_w0, 43'h2A5A5A5A5A5, v.tmpl, v.t0};
    word1_i   = {v.op, v.f_hi, 3'b101, v.f_lo20, 4'hA, v.btype, v.qp, v.f_mid23};
    addr_i    = v.addr;
    slot_i    = v.slot;
    pred_i    = v.pred;
    frame_i   = v.frame;
    epi_cnt_i = v.epi;
    priv_i    = v.priv;
    start_i   = 1'b1;
    @(negedge clk_i);
    start_i   = 1'b0;
  endtask

  task automatic check_all(input lbx_result_t e, input string tag);
    chk("R8", "done", 64'(done_o), 64'd1);
    chk(tag, "next_addr", next_addr_o, e.next_addr);
    chk(tag, "next_slot", 64'(next_slot_o), 64'(e.next_slot));
    chk(tag, "unhandled", 64'(unhandled_o), 64'(e.unhandled));
    chk(tag, "br_we", 64'(br_we_o), 64'(e.br_we));
    chk(tag, "br_idx", 64'(br_idx_o), 64'(e.br_idx));
    chk(tag, "br_data", br_data_o, e.br_data);
    chk(tag, "pfs_we", 64'(pfs_we_o), 64'(e.pfs_we));
    chk(tag, "pfs", pfs_o, e.pfs);
    chk(tag, "frame", frame_o, e.frame);
  endtask

  initial begin
    lbx_result_t e;
    string tag;
    logic [63:0] held;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8", "reset done", 64'(done_o), 64'd0);
    chk("R8", "reset next_addr", next_addr_o, 64'd0);
    chk("R8", "reset unhandled", 64'(unhandled_o), 64'd0);
    chk("R8", "reset frame", frame_o, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      e = model(VECS[i]);
      if (e.unhandled)            tag = "R1 R2";
      else if (VECS[i].op == 4'hD) tag = "R3 R5 R6 R7";
      else                         tag = "R3 R4 R9";
      apply(VECS[i]);
      check_all(e, tag);
      @(negedge clk_i);
    end

    // R8 outputs hold and done stays low without a start
    apply(VECS[3]);
    held = next_addr_o;
    repeat (3) @(negedge clk_i);
    chk("R8", "done low when idle", 64'(done_o), 64'd0);
    chk("R8", "next_addr held", next_addr_o, held);
    chk("R8", "br_we held", 64'(br_we_o), 64'd1);

    // R8 inputs changing without start have no effect
    word1_i = '0;
    addr_i  = 64'hDEAD;
    frame_i = 64'h1;
    repeat (2) @(negedge clk_i);
    chk("R8", "ignore idle inputs addr", next_addr_o, held);
    chk("R8", "ignore idle inputs frame", frame_o, model(VECS[3]).frame);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule